// File: doc/BRIEF.md
# CAN Acceptance Filter with Group Masks

This block chooses which message box, if any, accepts a frame just taken off the bus. Each box carries a configured identifier, an identifier format (standard or extended), a frame type (data or remote) and a role (receive or transmit). Only boxes numbered from zero up to a programmed highest box number take part. Among all boxes that accept the frame, the lowest-numbered one wins, and no other box gets the frame.

Two group functions can each be enabled and pointed at one box. A box picked this way compares its identifier through a per-bit ignore mask, so it catches a whole family of identifiers. When a group box wins, the block also raises a request to overwrite that box's stored identifier with the received one. The receive logic strobes the frame's identifier and flags into the filter. The outcome appears on the next clock and lasts one cycle. Message storage and bus reception sit outside the block.

Top module: `can_accept_filter`

## Requirements
- R1: A frame is captured on a clock edge where `frame_valid` is high. The result (`hit`, `hit_box`, `id_update`) is presented during the following clock cycle only. With no strobe in the previous cycle, `hit` and `id_update` are 0.
- R2: Box i can accept a frame only when i <= `top_box`.
- R3: A box accepts only frames whose type equals its configured type, where `box_rtr` bit 1 means remote frame, 0 means data frame, and `rx_rtr` = 1 marks a received remote frame.
- R4: A box accepts only frames whose format equals its `box_ext` bit (1 = extended). For standard frames only identifier bits 28..18 are compared and bits 17..0 are ignored. For extended frames all 29 bits (28..0) are compared.
- R5: A box whose `box_tx` bit is 1 (transmit role) never accepts a data frame.
- R6: When several boxes accept a frame, `hit_box` is the lowest-numbered one. `hit_box` is 0 whenever `hit` is 0.
- R7: Group g (g = 0 or 1) is enabled by `grp_en[g]` and applies to the box numbered `grp_sel[4g+3:4g]`. For that box, an identifier bit b whose mask bit `grp_mask[29g+b]` is 1 is left out of the comparison. Mask bits 2..0 of each group have no effect. If both groups name the same box, group 0's mask is used.
- R8: `id_update` is 1 exactly when `hit` is 1 and the winning box is named by an enabled group.
- R9: While `rst` is high, `hit`, `hit_box` and `id_update` are all 0 in the cycles after the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | Strobe: a received frame is present on the rx_* inputs |
| rx_id | input | 29 | Received identifier; a standard identifier sits in bits 28..18 |
| rx_ext | input | 1 | Received frame uses the extended format |
| rx_rtr | input | 1 | Received frame is a remote frame |
| box_id | input | 464 | Identifier of box i in bits [29i+28:29i] |
| box_ext | input | 16 | Per-box format, 1 = extended |
| box_rtr | input | 16 | Per-box frame type, 1 = remote |
| box_tx | input | 16 | Per-box role, 1 = transmit |
| top_box | input | 4 | Highest box number taking part in matching |
| grp_en | input | 2 | Enable of group 1 and group 0 |
| grp_sel | input | 8 | Box chosen by group 1 (bits 7..4) and group 0 (bits 3..0) |
| grp_mask | input | 58 | Ignore masks, group g in bits [29g+28:29g] |
| hit | output | 1 | Some box accepts the frame |
| hit_box | output | 4 | Number of the accepting box |
| id_update | output | 1 | Overwrite the winning group box's identifier with the received one |

## Verification
The hardest case to reach is a group box that matches only because of its mask. It must also coincide with a lower-numbered ordinary box, which has to take priority, or with an identifier that differs only in the three unused mask bits. The bench reaches these cases by flipping each identifier bit in turn against a group box whose mask covers exactly that bit, for both groups. A pseudo-random phase follows, drawing identifiers from a tiny pool so that several boxes match at once. That phase also moves the group selections over the same boxes. Separate sweeps place a single matching box at every position against every highest-box setting.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

    localparam int ID_W        = 29;
    localparam int STD_W       = 11;
    localparam int STD_LSB     = ID_W - STD_W;
    localparam int MASK_UNUSED = 3;
    localparam int NUM_GROUPS  = 2;

    typedef logic [ID_W-1:0] can_id_t;

    typedef enum logic {
        FT_DATA   = 1'b0,
        FT_REMOTE = 1'b1
    } ftype_e;

    typedef struct packed {
        can_id_t id;
        logic    ext;
        ftype_e  ftype;
    } frame_t;

    // Identifier bits that take part in a comparison for the given format.
    function automatic can_id_t care_bits(input logic ext);
        can_id_t c;
        if (ext) c = '1;
        else     c = {{STD_W{1'b1}}, {STD_LSB{1'b0}}};
        return c;
    endfunction

    // Group mask with the unused low bits forced to "compare".
    function automatic can_id_t usable_mask(input can_id_t m);
        can_id_t low;
        low = can_id_t'((1 << MASK_UNUSED) - 1);
        return m & ~low;
    endfunction

endpackage

// File: rtl/can_filt_box_cmp.sv
module can_filt_box_cmp
    import can_filt_pkg::*;
(
    input  frame_t  frame,
    input  can_id_t cfg_id,
    input  logic    cfg_ext,
    input  logic    cfg_rtr,
    input  logic    cfg_tx,
    input  logic    in_use,
    input  can_id_t ign_mask,
    output logic    match
);
    can_id_t care;
    logic    fmt_ok;
    logic    type_ok;
    logic    role_ok;
    logic    id_ok;

    always_comb begin
        care    = care_bits(frame.ext) & ~ign_mask;
        fmt_ok  = (cfg_ext == frame.ext);
        type_ok = (cfg_rtr == (frame.ftype == FT_REMOTE));
        role_ok = !(cfg_tx && (frame.ftype == FT_DATA));
        id_ok   = ((frame.id ^ cfg_id) & care) == '0;
        match   = in_use && fmt_ok && type_ok && role_ok && id_ok;
    end
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
    parameter int N  = 16,
    localparam int BW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [BW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = BW'(i);
            end
        end
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_BOXES = 16,
    localparam int BOX_W = (NUM_BOXES > 1) ? $clog2(NUM_BOXES) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_valid,
    input  logic [ID_W-1:0]               rx_id,
    input  logic                          rx_ext,
    input  logic                          rx_rtr,
    input  logic [NUM_BOXES*ID_W-1:0]     box_id,
    input  logic [NUM_BOXES-1:0]          box_ext,
    input  logic [NUM_BOXES-1:0]          box_rtr,
    input  logic [NUM_BOXES-1:0]          box_tx,
    input  logic [BOX_W-1:0]              top_box,
    input  logic [NUM_GROUPS-1:0]         grp_en,
    input  logic [NUM_GROUPS*BOX_W-1:0]   grp_sel,
    input  logic [NUM_GROUPS*ID_W-1:0]    grp_mask,
    output logic                          hit,
    output logic [BOX_W-1:0]              hit_box,
    output logic                          id_update
);
    frame_t               frame_q;
    logic                 vld_q;
    logic [NUM_BOXES-1:0] box_match;
    logic [NUM_BOXES-1:0] box_is_grp;
    logic                 any_match;
    logic [BOX_W-1:0]     win_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            frame_q <= '0;
        end else begin
            vld_q <= frame_valid;
            if (frame_valid) begin
                frame_q.id    <= rx_id;
                frame_q.ext   <= rx_ext;
                frame_q.ftype <= rx_rtr ? FT_REMOTE : FT_DATA;
            end
        end
    end

    for (genvar i = 0; i < NUM_BOXES; i++) begin : g_box
        can_id_t ign;
        logic    grp;
        logic    in_use;

        always_comb begin
            ign = '0;
            grp = 1'b0;
            for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
                if (grp_en[g] && (grp_sel[g*BOX_W +: BOX_W] == BOX_W'(i))) begin
                    ign = usable_mask(grp_mask[g*ID_W +: ID_W]);
                    grp = 1'b1;
                end
            end
            in_use = (BOX_W'(i) <= top_box);
        end

        assign box_is_grp[i] = grp;

        can_filt_box_cmp u_cmp (
            .frame    (frame_q),
            .cfg_id   (box_id[i*ID_W +: ID_W]),
            .cfg_ext  (box_ext[i]),
            .cfg_rtr  (box_rtr[i]),
            .cfg_tx   (box_tx[i]),
            .in_use   (in_use),
            .ign_mask (ign),
            .match    (box_match[i])
        );
    end

    can_filt_prio #(.N(NUM_BOXES)) u_prio (
        .req   (box_match),
        .found (any_match),
        .idx   (win_idx)
    );

    always_comb begin
        hit       = vld_q && any_match;
        hit_box   = hit ? win_idx : '0;
        id_update = hit && box_is_grp[win_idx];
    end
endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_valid,
    input logic        rx_ext,
    input logic        rx_rtr,
    input logic [15:0] box_ext,
    input logic [15:0] box_rtr,
    input logic [15:0] box_tx,
    input logic [3:0]  top_box,
    input logic [1:0]  grp_en,
    input logic [7:0]  grp_sel,
    input logic        hit,
    input logic [3:0]  hit_box,
    input logic        id_update
);
    AST_HIT_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(frame_valid)); // R1
    AST_BOX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_box <= top_box)); // R2
    AST_TYPE_EQUAL: assert property (@(posedge clk) disable iff (rst)
        hit |-> (box_rtr[hit_box] == $past(rx_rtr))); // R3
    AST_FORMAT_EQUAL: assert property (@(posedge clk) disable iff (rst)
        hit |-> (box_ext[hit_box] == $past(rx_ext))); // R4
    AST_TX_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (hit && !$past(rx_rtr)) |-> !box_tx[hit_box]); // R5
    AST_IDLE_BOX_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_box == 4'd0)); // R6
    AST_UPDATE_GROUP: assert property (@(posedge clk) disable iff (rst)
        id_update |-> (hit && ((grp_en[0] && grp_sel[3:0] == hit_box) ||
                               (grp_en[1] && grp_sel[7:4] == hit_box)))); // R8
endmodule

bind can_accept_filter can_filt_chk u_chk (.*);

// File: tb/sim_can_accept_filter.sv
module sim_can_accept_filter;
    import can_filt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 16;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                frame_valid = 1'b0;
    can_id_t             rx_id = '0;
    logic                rx_ext = 1'b0;
    logic                rx_rtr = 1'b0;
    can_id_t             b_id [NB];
    logic [NB*ID_W-1:0]  box_id;
    logic [NB-1:0]       box_ext = '0;
    logic [NB-1:0]       box_rtr = '0;
    logic [NB-1:0]       box_tx = '0;
    logic [3:0]          top_box = 4'd15;
    logic [1:0]          grp_en = 2'b00;
    logic [7:0]          grp_sel = 8'h00;
    can_id_t             gm0 = '0;
    can_id_t             gm1 = '0;
    logic [2*ID_W-1:0]   grp_mask;
    logic                hit;
    logic [3:0]          hit_box;
    logic                id_update;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic       l_hit;
    logic [3:0] l_box;
    logic       l_upd;

    localparam can_id_t ID_A = {11'h2A5, 18'h00000};
    localparam can_id_t ID_B = {11'h13C, 18'h00000};

    always_comb begin
        for (int i = 0; i < NB; i++) box_id[i*ID_W +: ID_W] = b_id[i];
    end
    assign grp_mask = {gm1, gm0};

    always #(CLK_PERIOD/2) clk = ~clk;

    can_accept_filter u0 (
        .clk(clk), .rst(rst), .frame_valid(frame_valid),
        .rx_id(rx_id), .rx_ext(rx_ext), .rx_rtr(rx_rtr),
        .box_id(box_id), .box_ext(box_ext), .box_rtr(box_rtr), .box_tx(box_tx),
        .top_box(top_box), .grp_en(grp_en), .grp_sel(grp_sel), .grp_mask(grp_mask),
        .hit(hit), .hit_box(hit_box), .id_update(id_update)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected outcome from the requirements (R2..R8).
    task automatic ref_match(input can_id_t id, input logic ext, input logic rtr,
                             output logic h, output logic [3:0] bx, output logic up);
        h = 1'b0; bx = 4'd0; up = 1'b0;
        for (int i = NB - 1; i >= 0; i--) begin
            can_id_t care;
            can_id_t m;
            logic    grp;
            care = ext ? 29'h1FFFFFFF : 29'h1FFC0000;
            m = '0; grp = 1'b0;
            if (grp_en[1] && grp_sel[7:4] == 4'(i)) begin m = gm1; grp = 1'b1; end
            if (grp_en[0] && grp_sel[3:0] == 4'(i)) begin m = gm0; grp = 1'b1; end
            care = care & ~(m & 29'h1FFFFFF8);
            if (i <= int'(top_box) && box_ext[i] == ext && box_rtr[i] == rtr &&
                !(box_tx[i] && !rtr) && ((id ^ b_id[i]) & care) == '0) begin
                h = 1'b1; bx = 4'(i); up = grp;
            end
        end
    endtask

    task automatic send(input can_id_t id, input logic ext, input logic rtr, input string req);
        logic eh; logic [3:0] eb; logic eu;
        @(negedge clk);
        rx_id = id; rx_ext = ext; rx_rtr = rtr; frame_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frame_valid = 1'b0;
        ref_match(id, ext, rtr, eh, eb, eu);
        l_hit = hit; l_box = hit_box; l_upd = id_update;
        chk({req, " hit"}, 32'(hit), 32'(eh));
        chk({req, " hit_box"}, 32'(hit_box), 32'(eb));
        chk({req, " id_update"}, 32'(id_update), 32'(eu));
        @(posedge clk);
    endtask

    task automatic fill(input can_id_t id);
        for (int i = 0; i < NB; i++) b_id[i] = id;
        box_ext = '0; box_rtr = '0; box_tx = '0;
        grp_en = 2'b00; grp_sel = 8'h00; gm0 = '0; gm1 = '0; top_box = 4'd15;
    endtask

    initial begin
        fill(ID_B);
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 hit in reset", 32'(hit), 0);
        chk("R9 hit_box in reset", 32'(hit_box), 0);
        chk("R9 id_update in reset", 32'(id_update), 0);
        rst = 1'b0;

        // R1: timing and one-cycle result
        b_id[0] = ID_A;
        @(negedge clk);
        rx_id = ID_A; rx_ext = 1'b0; rx_rtr = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R1 no strobe no hit", 32'(hit), 0);
        end
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        chk("R1 hit cycle after strobe", 32'(hit), 1);
        @(negedge clk);
        chk("R1 hit lasts one cycle", 32'(hit), 0);
        @(posedge clk);

        // R6: all boxes match, lowest wins for every top_box
        fill(ID_A);
        for (int t = 0; t < NB; t++) begin
            top_box = 4'(t);
            send(ID_A, 1'b0, 1'b0, "R6 all match");
            chk("R6 lowest box", 32'(l_box), 0);
        end

        // R2: single matching box k against every top_box
        for (int k = 0; k < NB; k++) begin
            for (int t = 0; t < NB; t++) begin
                fill(ID_B);
                b_id[k] = ID_A;
                top_box = 4'(t);
                send(ID_A, 1'b0, 1'b0, "R2 range");
                chk("R2 range hit", 32'(l_hit), 32'(k <= t));
            end
        end

        // R3: frame type
        fill(ID_B);
        b_id[0] = ID_A; box_rtr[0] = 1'b1;
        b_id[1] = ID_A;
        send(ID_A, 1'b0, 1'b0, "R3 data");
        chk("R3 data to box1", 32'(l_box), 1);
        send(ID_A, 1'b0, 1'b1, "R3 remote");
        chk("R3 remote to box0", 32'(l_box), 0);

        // R4: format and compared bits
        fill(ID_B);
        b_id[2] = ID_A | 29'h0003_1234;
        send(ID_A, 1'b0, 1'b0, "R4 std low bits ignored");
        chk("R4 std low bits ignored box", 32'(l_box), 2);
        send(ID_A, 1'b1, 1'b0, "R4 ext vs std box");
        chk("R4 ext frame no std box", 32'(l_hit), 0);
        fill(ID_B);
        box_ext[5] = 1'b1; b_id[5] = ID_A | 29'h1;
        send(ID_A | 29'h1, 1'b1, 1'b0, "R4 ext exact");
        chk("R4 ext exact box", 32'(l_box), 5);
        send(ID_A, 1'b1, 1'b0, "R4 ext bit0 differs");
        chk("R4 ext bit0 differs", 32'(l_hit), 0);

        // R5: transmit boxes
        fill(ID_B);
        b_id[0] = ID_A; box_tx[0] = 1'b1;
        b_id[1] = ID_A;
        send(ID_A, 1'b0, 1'b0, "R5 data skips tx");
        chk("R5 data skips tx box", 32'(l_box), 1);
        box_rtr[0] = 1'b1;
        send(ID_A, 1'b0, 1'b1, "R5 remote to tx");
        chk("R5 remote to tx box", 32'(l_box), 0);

        // R7/R8: group masks, each bit, both groups
        for (int g = 0; g < 2; g++) begin
            for (int b = 0; b < ID_W; b++) begin
                can_id_t m;
                m = can_id_t'(1) << b;
                fill(ID_B);
                box_ext = '1; b_id[9] = ID_A | 29'h155;
                grp_en[g] = 1'b1;
                grp_sel = (g == 0) ? 8'h09 : 8'h90;
                if (g == 0) gm0 = m; else gm1 = m;
                send((ID_A | 29'h155) ^ m, 1'b1, 1'b0, "R7 mask bit");
                chk("R7 mask bit hit", 32'(l_hit), 32'(b >= 3));
                chk("R8 update on group hit", 32'(l_upd), 32'(b >= 3));
            end
        end
        // R7: disabled group, priority of group 0, lower box wins
        fill(ID_B);
        b_id[4] = ID_A; grp_sel = 8'h44; gm0 = 29'h0004_0000; gm1 = 29'h1FFFFFF8;
        grp_en = 2'b11;
        send(ID_B | 29'h0004_0000, 1'b0, 1'b0, "R7 group0 mask on shared box");
        chk("R7 group0 precedence", 32'(l_hit), 0);
        grp_en = 2'b00;
        send(ID_A ^ 29'h0004_0000, 1'b0, 1'b0, "R7 disabled");
        chk("R7 disabled group", 32'(l_hit), 0);
        grp_en = 2'b01; gm0 = 29'h1FFC0000; b_id[2] = ID_A;
        send(ID_A, 1'b0, 1'b0, "R8 lower plain box");
        chk("R8 plain winner no update", 32'(l_upd), 0);
        chk("R6 lower plain box wins", 32'(l_box), 2);

        // R6: pseudo-random mix
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < NB; i++) b_id[i] = ($urandom % 2) ? ID_A : (ID_A ^ 29'h0008_0000);
            box_ext = 16'($urandom); box_rtr = 16'($urandom); box_tx = 16'($urandom);
            top_box = 4'($urandom); grp_en = 2'($urandom); grp_sel = 8'($urandom);
            gm0 = ($urandom % 2) ? 29'h0008_0000 : 29'h0000_0007;
            gm1 = 29'($urandom);
            send(($urandom % 2) ? ID_A : (ID_A ^ 29'h0008_0000), 1'($urandom), 1'($urandom), "R6 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule